// File: doc/BRIEF.md
# SPI Transfer Length Command Generator

This block sits in front of a generic SPI command queue. It takes one transfer request at a time, made of a byte count, a direction, a DMA-receive flag and a command-phase flag. It turns that request into a stream of 20-bit command entries. A downstream engine executes the entries. This block only decides how the request is encoded.

Each entry has an 8-bit immediate field. When a data count does not fit in that field, the generator splits it. While more than 255 bytes remain, it emits exponent-coded chunks of 2^n bytes, where n is the lowest set bit of the remainder at position 8 or above. Any remainder left over goes out as one plain entry whose immediate is the byte count. For DMA receives that plain count is padded up to a word multiple. A command-phase request emits one transmit entry per opcode or address byte instead. Every entry also reports how many request bytes it consumes.

Top module: `xcg_top`

## Requirements
- R1: After reset `req_ready` is 1 and `cmd_valid` is 0.
- R2: Every entry uses this layout: bits [11:10] = 01 (single-line SPI), bit 12 = 1 and bit 14 = 1 (lower chip select and lower bus), bits 13, 15, 18 and 19 = 0. Bit 16 is set for transmit and bit 17 is set for receive (`req_rx` = 1), never both.
- R3: A data entry is exponent-coded while the remaining count exceeds 255. Such an entry has bit 9 = 1, bit 8 = 1, and immediate [7:0] = n, where n is the lowest set bit of the remainder at position 8 or above. `cmd_bytes` = 2^n, and 2^n is then taken off the remainder. Values of n from 8 to 31 can occur.
- R4: A nonzero remainder of 255 or less produces one final entry. It has bit 9 = 0, bit 8 = 1, immediate = remainder and `cmd_bytes` = remainder. If the remainder reaches zero after an exponent chunk, no final entry follows.
- R5: For a receive with `req_dma` = 1, the final non-exponent entry has its immediate rounded up to a multiple of 4, truncated to 8 bits, so 253 to 255 give 0. `cmd_bytes` keeps the unrounded count. Exponent entries, transmit entries and non-DMA receives are never rounded.
- R6: With `req_cmd` = 1, `req_len` entries are emitted, one per byte. Byte i comes from `req_cmd_bytes[8i+7:8i]`, lowest byte first, and goes in the immediate. Each entry has bit 8 = 0, bit 9 = 0, bit 16 = 1 and `cmd_bytes` = 1. `req_rx` and `req_dma` have no effect on these entries. `req_len` must not exceed CMD_MAX.
- R7: A request with `req_len` = 0 is accepted and produces no entry. `req_ready` stays 1.
- R8: After accepting a nonzero request, `req_ready` stays 0 until the last entry of that request is taken. It is 1 again in the following cycle.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_word` and `cmd_bytes` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Generator idle, request taken this cycle |
| req_len | input | 32 | Byte count of the request |
| req_rx | input | 1 | 1 = receive, 0 = transmit |
| req_dma | input | 1 | Receive goes to DMA (word-padded count) |
| req_cmd | input | 1 | Command-phase request, one entry per byte |
| req_cmd_bytes | input | 32 | Command bytes, lowest byte sent first |
| cmd_valid | output | 1 | Entry available |
| cmd_ready | input | 1 | Downstream takes the entry |
| cmd_word | output | 20 | Encoded command entry |
| cmd_bytes | output | 32 | Request bytes this entry consumes |

## Verification
The checker takes for granted that a command-phase request never asks for more bytes than `req_cmd_bytes` can carry. Under that assumption, any entry with bit 8 clear is a one-byte transmit entry. The checker also assumes `cmd_ready` may do anything, so backpressure of any length must leave the offered entry untouched. The stimulus keeps command-phase lengths between 0 and CMD_MAX. It stalls the output by a random 0 to 2 cycles per entry, so both the held and the flowing cases of the handshake are exercised.

// File: rtl/xcg_pkg.sv
package xcg_pkg;
  localparam int IMM_W  = 8;
  localparam int WORD_W = 20;

  // field positions a downstream engine decodes
  localparam int P_XFER   = 8;
  localparam int P_EXP    = 9;
  localparam int P_MODE   = 10;
  localparam int P_CS_LO  = 12;
  localparam int P_BUS_LO = 14;
  localparam int P_TX     = 16;
  localparam int P_RX     = 17;
  localparam logic [1:0] MODE_SINGLE = 2'b01;

  typedef struct packed {
    logic [IMM_W-1:0] imm;
    logic             xfer;
    logic             expo;
    logic             rx;
  } entry_t;

  // pad a byte count to a word multiple inside the 8-bit field
  function automatic logic [IMM_W-1:0] pad_word(input logic [IMM_W-1:0] v);
    logic [IMM_W-1:0] s;
    s = v + IMM_W'(3);
    return {s[IMM_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/xcg_split.sv
module xcg_split
  import xcg_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic [LEN_W-1:0] rem,
  input  logic             pad_en,
  output logic             use_exp,
  output logic [IMM_W-1:0] imm,
  output logic [LEN_W-1:0] chunk
);
  localparam int EXP_W = $clog2(LEN_W);

  // lowest set bit at or above the immediate width
  function automatic logic [EXP_W-1:0] low_hi_bit(input logic [LEN_W-1:0] r);
    logic [EXP_W-1:0] res;
    res = '0;
    for (int i = LEN_W - 1; i >= IMM_W; i--) begin
      if (r[i]) res = EXP_W'(i);
    end
    return res;
  endfunction

  logic [EXP_W-1:0] e;
  logic [IMM_W-1:0] tail;

  always_comb begin
    use_exp = |rem[LEN_W-1:IMM_W];
    e       = low_hi_bit(rem);
    tail    = rem[IMM_W-1:0];
    if (use_exp) begin
      imm   = IMM_W'(e);
      chunk = {{(LEN_W-1){1'b0}}, 1'b1} << e;
    end else begin
      imm   = (pad_en && (tail[1:0] != 2'b00)) ? pad_word(tail) : tail;
      chunk = rem;
    end
  end
endmodule

// File: rtl/xcg_pack.sv
module xcg_pack
  import xcg_pkg::*;
(
  input  entry_t            f,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word                       = '0;
    word[IMM_W-1:0]            = f.imm;
    word[P_XFER]               = f.xfer;
    word[P_EXP]                = f.expo;
    word[P_MODE+1:P_MODE]      = MODE_SINGLE;
    word[P_CS_LO]              = 1'b1;
    word[P_BUS_LO]             = 1'b1;
    word[P_TX]                 = ~f.rx;
    word[P_RX]                 = f.rx;
  end
endmodule

// File: rtl/xcg_top.sv
module xcg_top
  import xcg_pkg::*;
#(
  parameter int LEN_W   = 32,
  parameter int CMD_MAX = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 req_rx,
  input  logic                 req_dma,
  input  logic                 req_cmd,
  input  logic [8*CMD_MAX-1:0] req_cmd_bytes,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [WORD_W-1:0]    cmd_word,
  output logic [LEN_W-1:0]     cmd_bytes
);
  localparam int CMD_W = 8 * CMD_MAX;

  logic             busy;
  logic [LEN_W-1:0] rem;
  logic             rx_q, dma_q, cmd_q;
  logic [CMD_W-1:0] cbuf;

  logic             use_exp;
  logic [IMM_W-1:0] split_imm;
  logic [LEN_W-1:0] split_chunk;
  logic [LEN_W-1:0] step;
  logic [LEN_W-1:0] rem_after;
  entry_t           ent;

  // named events for the checker
  logic req_take;
  logic entry_fire;
  logic last_fire;

  xcg_split #(.LEN_W(LEN_W)) u_split (
    .rem    (rem),
    .pad_en (dma_q & rx_q & ~cmd_q),
    .use_exp(use_exp),
    .imm    (split_imm),
    .chunk  (split_chunk)
  );

  always_comb begin
    if (cmd_q) begin
      ent.imm  = cbuf[7:0];
      ent.xfer = 1'b0;
      ent.expo = 1'b0;
      ent.rx   = 1'b0;
      step     = {{(LEN_W-1){1'b0}}, 1'b1};
    end else begin
      ent.imm  = split_imm;
      ent.xfer = 1'b1;
      ent.expo = use_exp;
      ent.rx   = rx_q;
      step     = split_chunk;
    end
  end

  xcg_pack u_pack (
    .f   (ent),
    .word(cmd_word)
  );

  assign req_ready  = ~busy;
  assign cmd_valid  = busy;
  assign cmd_bytes  = step;
  assign rem_after  = rem - step;
  assign req_take   = req_valid & ~busy;
  assign entry_fire = busy & cmd_ready;
  assign last_fire  = entry_fire & (rem_after == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rem   <= '0;
      rx_q  <= 1'b0;
      dma_q <= 1'b0;
      cmd_q <= 1'b0;
      cbuf  <= '0;
    end else if (req_take) begin
      busy  <= (req_len != '0);
      rem   <= req_len;
      rx_q  <= req_rx;
      dma_q <= req_dma;
      cmd_q <= req_cmd;
      cbuf  <= req_cmd_bytes;
    end else if (entry_fire) begin
      rem  <= rem_after;
      cbuf <= cbuf >> 8;
      if (rem_after == '0) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/xcg_chk.sv
module xcg_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [19:0]      cmd_word,
  input logic [LEN_W-1:0] cmd_bytes,
  input logic             entry_fire,
  input logic             last_fire
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word) && $stable(cmd_bytes));

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len == '0) |=> !cmd_valid && req_ready);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_len != '0) |=> cmd_valid && !req_ready);

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> req_ready && !cmd_valid);

  // R4
  final_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_fire && cmd_word[8] && !cmd_word[9] |-> last_fire);

  // R3
  exp_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[9] |-> (cmd_word[7:0] >= 8'd8) && cmd_word[8]
      && (cmd_bytes == ({{(LEN_W-1){1'b0}}, 1'b1} << cmd_word[7:0])));

  // R2
  layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_word[11:10] == 2'b01) && cmd_word[12] && cmd_word[14]
      && !cmd_word[13] && !cmd_word[15] && (cmd_word[19:18] == 2'b00)
      && (cmd_word[16] ^ cmd_word[17]));

  // R6
  cmd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_word[8] |-> cmd_word[16] && !cmd_word[9] && (cmd_bytes == LEN_W'(1)));
endmodule

bind xcg_top xcg_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_xcg_top.sv
module tb_xcg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_len = '0;
  logic        req_rx = 1'b0;
  logic        req_dma = 1'b0;
  logic        req_cmd = 1'b0;
  logic [31:0] req_cmd_bytes = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [19:0] cmd_word;
  logic [31:0] cmd_bytes;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [19:0] ew[$];
  logic [31:0] eb[$];

  always #2.5 clk = ~clk;

  xcg_top dut (.*);

  function automatic logic [19:0] mk(input logic [7:0] imm, input logic xfer,
                                      input logic expo, input logic rx);
    return {2'b00, rx, ~rx, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, expo, xfer, imm};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic plan(input logic [31:0] len, input bit rx, input bit dma,
                      input bit cmd, input logic [31:0] cb);
    logic [31:0] r, hi, low;
    logic [7:0]  imm;
    ew.delete(); eb.delete();
    if (cmd) begin
      for (int i = 0; i < int'(len); i++) begin
        ew.push_back(mk(cb[8*i +: 8], 1'b0, 1'b0, 1'b0));
        eb.push_back(32'd1);
      end
    end else begin
      r = len;
      while (r > 32'd255) begin
        hi  = r & 32'hFFFF_FF00;
        low = hi & (~hi + 32'd1);
        ew.push_back(mk(8'($clog2(low)), 1'b1, 1'b1, rx));
        eb.push_back(low);
        r = r - low;
      end
      if (r != 0) begin
        imm = r[7:0];
        if (rx && dma && (r % 4 != 0)) imm = 8'((r + 3) / 4 * 4);
        ew.push_back(mk(imm, 1'b1, 1'b0, rx));
        eb.push_back(r);
      end
    end
  endtask

  function automatic string tag_of(input logic [19:0] w, input bit rx, input bit dma);
    if (!w[8]) return "R6";
    if (w[9]) return "R3";
    if (rx && dma) return "R5";
    return "R4";
  endfunction

  task automatic run(input logic [31:0] len, input bit rx, input bit dma,
                     input bit cmd, input logic [31:0] cb);
    logic [19:0] w;
    logic [31:0] b;
    string t;
    int stall;
    plan(len, rx, dma, cmd, cb);
    @(negedge clk);
    req_len = len; req_rx = rx; req_dma = dma; req_cmd = cmd; req_cmd_bytes = cb;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_len = $urandom; req_cmd_bytes = $urandom;
    if (ew.size() == 0) begin
      // R7: zero length leaves no entry and stays ready
      check(!cmd_valid && req_ready, "R7", {cmd_valid, req_ready}, 2'b01);
    end else begin
      check(!req_ready, "R8", req_ready, 0);
    end
    while (ew.size() != 0) begin
      while (!cmd_valid) @(negedge clk);
      w = ew[0]; b = eb[0];
      t = tag_of(w, rx && !cmd, dma);
      check(cmd_word[19:10] == w[19:10], "R2", cmd_word, w);
      check(cmd_word[9:0] == w[9:0] && cmd_bytes == b, t,
            {cmd_word, cmd_bytes}, {w, b});
      stall = $urandom % 3;
      for (int s = 0; s < stall; s++) begin
        cmd_ready = 1'b0;
        @(negedge clk);
        check(cmd_valid && cmd_word == w && cmd_bytes == b, "R9",
              {cmd_valid, cmd_word}, {1'b1, w});
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      void'(ew.pop_front()); void'(eb.pop_front());
      if (ew.size() != 0) check(!req_ready, "R8", req_ready, 0);
    end
    check(req_ready && !cmd_valid, "R8", {req_ready, cmd_valid}, 2'b10);
  endtask

  initial begin
    logic [31:0] len;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1
    check(req_ready && !cmd_valid, "R1", {req_ready, cmd_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !cmd_valid, "R1", {req_ready, cmd_valid}, 2'b10);

    run(32'd0, 1'b0, 1'b0, 1'b0, '0);              // R7
    run(32'd0, 1'b0, 1'b0, 1'b1, 32'h11223344);    // R7 command
    run(32'd255, 1'b0, 1'b0, 1'b0, '0);            // R4 largest immediate
    run(32'd256, 1'b1, 1'b1, 1'b0, '0);            // R3 single chunk, no tail
    run(32'd257, 1'b0, 1'b0, 1'b0, '0);            // R3 then R4
    run(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, '0);      // R3 exponents 8..31
    run(32'h8000_0000, 1'b0, 1'b0, 1'b0, '0);      // R3 exponent 31
    run(32'd5, 1'b1, 1'b1, 1'b0, '0);              // R5 pad to 8
    run(32'd5, 1'b1, 1'b0, 1'b0, '0);              // R5 no pad without DMA
    run(32'd5, 1'b0, 1'b1, 1'b0, '0);              // R5 no pad on transmit
    run(32'd253, 1'b1, 1'b1, 1'b0, '0);            // R5 wraps to 0
    run(32'd1023, 1'b1, 1'b1, 1'b0, '0);           // R5 tail 255 padded
    run(32'd3, 1'b0, 1'b0, 1'b1, 32'h00A1B2C3);    // R6
    run(32'd4, 1'b1, 1'b1, 1'b1, 32'hDEADBEEF);    // R6 ignores rx/dma

    for (int k = 0; k < 300; k++) begin
      case ($urandom % 4)
        0: len = $urandom % 300;
        1: len = $urandom & 32'h0000_FFFF;
        2: len = $urandom;
        default: len = 256 * ($urandom % 8) + ($urandom % 4);
      endcase
      if ($urandom % 8 == 0)
        run($urandom % 5, $urandom % 2, $urandom % 2, 1'b1, $urandom);
      else
        run(len, $urandom % 2, $urandom % 2, 1'b0, '0);
    end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule